// File: doc/BRIEF.md
# Write Payload Byte-Enable Generator

This block produces, for every beat of a write request carried on a 512-bit stream, one enable bit per byte lane. A bit is set only where a real payload byte sits. Lanes that hold the request descriptor, the filler gap in front of the payload, or nothing past the payload's end stay clear. The block needs a handful of values from the first beat of the packet:

- the byte-enable nibble for the first payload Dword;
- the byte-enable nibble for the last payload Dword;
- the payload length in Dwords;
- a zero-length flag;
- the Dword lane where the payload begins.

From these it derives the enables for that beat and for every later beat of the same packet. It keeps a running payload-Dword offset that advances only on accepted beats. The two nibbles are also echoed on a sideband, on the first beat only. A consumer can use the enable vector directly as a byte write mask.

Byte lane `4*d+b` is byte `b` (bits `8b+7:8b`) of Dword lane `d`. Bit `b` of a nibble enables byte `b` of its Dword. Payload Dword `p` of the packet sits in beat `(p+S)/16`, Dword lane `(p+S)%16`, where `S` is the start lane.

Top module: `wr_byte_en_gen`

## Requirements
- R1: On the first beat (`beat_valid=1`, `beat_sop=1`), every byte lane in Dword lanes below `hdr_start_dw` (descriptor and gap) is 0; `hdr_start_dw` is at least 4.
- R2: A byte lane whose Dword holds no payload Dword (before the start, or at or after payload index `hdr_dw_cnt`) is 0.
- R3: The Dword lane holding payload Dword 0 carries `hdr_first_be` when the length is 2 or more.
- R4: The Dword lane holding the final payload Dword (index `hdr_dw_cnt-1`, length 2 or more) carries `hdr_last_be`, even when it falls in a later beat.
- R5: Payload Dwords strictly between the first and the last have all four enables set. For a length above 2 with `hdr_first_be` in {1111,1110,1100,1000} and `hdr_last_be` in {1111,0111,0011,0001}, the set bits of each beat form one contiguous run.
- R6: With a length of 1, only `hdr_first_be` applies to the single Dword and `hdr_last_be` is ignored.
- R7: With a length of 2, the first and last nibbles apply independently, so the set bits may be non-contiguous (for example 0001 then 1000).
- R8: With `hdr_zero_len=1`, `hdr_dw_cnt` is ignored, one payload Dword is placed at the start lane, and every enable bit of the beat is 0.
- R9: `sb_first_be`/`sb_last_be` equal `hdr_first_be`/`hdr_last_be` on a valid first beat and are 0 on any other cycle.
- R10: A beat is accepted when `beat_valid` and `beat_ready` are both 1. Each accepted non-first beat advances the payload index of Dword lane 0 by 16. A beat held with `beat_ready=0` repeats the same enables.
- R11: With `beat_valid=0`, all enable bits are 0.
- R12: After reset, a valid non-first beat seen before any first beat yields all-zero enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | A stream beat is present |
| beat_ready | input | 1 | The consumer accepts the beat |
| beat_sop | input | 1 | The beat is the first of its packet |
| hdr_first_be | input | 4 | Enables of the first payload Dword (first beat) |
| hdr_last_be | input | 4 | Enables of the last payload Dword (first beat) |
| hdr_dw_cnt | input | 11 | Payload length in Dwords, 1 to 1024 (first beat) |
| hdr_zero_len | input | 1 | Zero-length write (first beat) |
| hdr_start_dw | input | 4 | Dword lane of payload Dword 0 in the first beat |
| lane_be | output | 64 | Per-byte-lane payload enable of the current beat |
| sb_first_be | output | 4 | First-Dword nibble echoed on the first beat |
| sb_last_be | output | 4 | Last-Dword nibble echoed on the first beat |

## Verification
The first-Dword nibble and the last-Dword nibble can both land in one beat, and even in adjacent lanes. The final Dword can also spill into lane 0 of the next beat while the first beat's sideband is shown. These merges are provoked with short payloads (one, two and three Dwords) at start lanes near the top of the beat, such as lane 14 or 15, and with longer payloads whose end falls on lane 0. Each beat is judged lane by lane against a byte-level model of the requirements, and a stalled beat is checked to repeat before the offset moves.

// File: rtl/wbe_pkg.sv
`timescale 1ns/1ps
package wbe_pkg;

    // Bytes per Dword; fixed by the nibble-wide byte enables.
    localparam int DW_BYTES = 4;

    typedef logic [DW_BYTES-1:0] nib_t;

    // What a given Dword lane holds in the current beat.
    typedef enum logic [2:0] {
        ROLE_OUTSIDE,   // descriptor, gap, or past the end
        ROLE_NULL,      // the lone Dword of a zero-length write
        ROLE_ONLY,      // single-Dword payload
        ROLE_HEAD,      // first of two or more
        ROLE_BODY,      // strictly between first and last
        ROLE_TAIL       // last of two or more
    } dw_role_e;

    // Packet-wide context captured from the first beat.
    typedef struct packed {
        nib_t head_be;
        nib_t tail_be;
        logic null_wr;
    } be_ctx_t;

    function automatic dw_role_e classify(input int idx, input int len, input logic null_wr);
        if (idx < 0 || idx >= len) return ROLE_OUTSIDE;
        if (null_wr)               return ROLE_NULL;
        if (len == 1)              return ROLE_ONLY;
        if (idx == 0)              return ROLE_HEAD;
        if (idx == len - 1)        return ROLE_TAIL;
        return ROLE_BODY;
    endfunction

    function automatic nib_t role_nibble(input dw_role_e role, input be_ctx_t ctx);
        case (role)
            ROLE_ONLY, ROLE_HEAD: return ctx.head_be;
            ROLE_TAIL:            return ctx.tail_be;
            ROLE_BODY:            return '1;
            default:              return '0;
        endcase
    endfunction

    // Legal first-Dword enables for payloads above two Dwords.
    function automatic logic head_legal(input nib_t be);
        return (be == 4'b1111) || (be == 4'b1110) || (be == 4'b1100) || (be == 4'b1000);
    endfunction

    // Legal last-Dword enables for payloads above two Dwords.
    function automatic logic tail_legal(input nib_t be);
        return (be == 4'b1111) || (be == 4'b0111) || (be == 4'b0011) || (be == 4'b0001);
    endfunction

endpackage

// File: rtl/wbe_hdr_track.sv
`timescale 1ns/1ps
module wbe_hdr_track
    import wbe_pkg::*;
#(
    parameter int BEAT_DW = 16,
    parameter int LEN_W   = 11,
    parameter int OFS_W   = 13,
    parameter int LANE_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    beat_valid,
    input  logic                    beat_ready,
    input  logic                    beat_sop,
    input  nib_t                    hdr_first_be,
    input  nib_t                    hdr_last_be,
    input  logic [LEN_W-1:0]        hdr_dw_cnt,
    input  logic                    hdr_zero_len,
    input  logic [LANE_W-1:0]       hdr_start_dw,
    output be_ctx_t                 cur_ctx,
    output logic [LEN_W-1:0]        cur_len,
    output logic signed [OFS_W-1:0] cur_base
);

    localparam logic [OFS_W-1:0] BEAT_STEP = OFS_W'(BEAT_DW);

    logic                    accept;
    be_ctx_t                 live_ctx;
    be_ctx_t                 ctx_q;
    logic [LEN_W-1:0]        live_len;
    logic [LEN_W-1:0]        len_q;
    logic signed [OFS_W-1:0] start_ext;
    logic signed [OFS_W-1:0] live_base;
    logic signed [OFS_W-1:0] base_q;

    assign accept    = beat_valid && beat_ready;
    assign start_ext = $signed(OFS_W'(hdr_start_dw));
    assign live_base = -start_ext;

    always_comb begin
        live_ctx.head_be = hdr_first_be;
        live_ctx.tail_be = hdr_last_be;
        live_ctx.null_wr = hdr_zero_len;
        // A zero-length write still occupies one Dword slot.
        live_len         = hdr_zero_len ? LEN_W'(1) : hdr_dw_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            if (beat_sop) begin
                ctx_q  <= live_ctx;
                len_q  <= live_len;
                base_q <= live_base + $signed(BEAT_STEP);
            end else begin
                base_q <= base_q + $signed(BEAT_STEP);
            end
        end
    end

    // The first beat is served from the live header, later beats from the capture.
    assign cur_ctx  = beat_sop ? live_ctx  : ctx_q;
    assign cur_len  = beat_sop ? live_len  : len_q;
    assign cur_base = beat_sop ? live_base : base_q;

    AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_sop) |=>
            (beat_sop || cur_base == $past(cur_base) + $signed(BEAT_STEP))) else $error("base step"); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready && !beat_sop) |=> $stable(cur_base)) else $error("stall hold"); // R10

endmodule

// File: rtl/wbe_lane_map.sv
`timescale 1ns/1ps
module wbe_lane_map
    import wbe_pkg::*;
#(
    parameter int BEAT_DW = 16,
    parameter int LEN_W   = 11,
    parameter int OFS_W   = 13
) (
    input  logic                         beat_valid,
    input  be_ctx_t                      ctx,
    input  logic [LEN_W-1:0]             len,
    input  logic signed [OFS_W-1:0]      base,
    output logic [BEAT_DW*DW_BYTES-1:0]  lane_be
);

    dw_role_e roles [BEAT_DW];

    for (genvar d = 0; d < BEAT_DW; d++) begin : g_dw
        logic signed [OFS_W-1:0] idx;
        assign idx = base + $signed(OFS_W'(d));

        always_comb begin
            roles[d] = classify(int'(idx), int'(len), ctx.null_wr);
        end

        assign lane_be[d*DW_BYTES +: DW_BYTES] = beat_valid ? role_nibble(roles[d], ctx) : '0;
    end

    // At most one head and one tail lane may exist in any beat.
    always_comb begin
        int heads;
        int tails;
        heads = 0;
        tails = 0;
        for (int d = 0; d < BEAT_DW; d++) begin
            if (roles[d] == ROLE_HEAD || roles[d] == ROLE_ONLY || roles[d] == ROLE_NULL) heads++;
            if (roles[d] == ROLE_TAIL) tails++;
        end
        AST_ONE_HEAD: assert (heads <= 1 && tails <= 1) else $error("role count"); // R3
    end

endmodule

// File: rtl/wbe_sideband.sv
`timescale 1ns/1ps
module wbe_sideband
    import wbe_pkg::*;
(
    input  logic beat_valid,
    input  logic beat_sop,
    input  nib_t hdr_first_be,
    input  nib_t hdr_last_be,
    output nib_t sb_first_be,
    output nib_t sb_last_be
);

    logic show;
    assign show        = beat_valid && beat_sop;
    assign sb_first_be = show ? hdr_first_be : '0;
    assign sb_last_be  = show ? hdr_last_be  : '0;

endmodule

// File: rtl/wr_byte_en_gen.sv
`timescale 1ns/1ps
module wr_byte_en_gen
    import wbe_pkg::*;
#(
    parameter int BEAT_DW = 16,
    parameter int DESC_DW = 4,
    parameter int LEN_W   = 11
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               beat_valid,
    input  logic                               beat_ready,
    input  logic                               beat_sop,
    input  logic [3:0]                         hdr_first_be,
    input  logic [3:0]                         hdr_last_be,
    input  logic [LEN_W-1:0]                   hdr_dw_cnt,
    input  logic                               hdr_zero_len,
    input  logic [$clog2(BEAT_DW)-1:0]         hdr_start_dw,
    output logic [BEAT_DW*4-1:0]               lane_be,
    output logic [3:0]                         sb_first_be,
    output logic [3:0]                         sb_last_be
);

    localparam int LANE_W = $clog2(BEAT_DW);
    localparam int OFS_W  = LEN_W + 2;
    localparam int BYTES  = BEAT_DW * DW_BYTES;
    localparam int DESC_B = DESC_DW * DW_BYTES;

    be_ctx_t                 cur_ctx;
    logic [LEN_W-1:0]        cur_len;
    logic signed [OFS_W-1:0] cur_base;

    wbe_hdr_track #(
        .BEAT_DW (BEAT_DW),
        .LEN_W   (LEN_W),
        .OFS_W   (OFS_W),
        .LANE_W  (LANE_W)
    ) u_track (
        .clk          (clk),
        .rst          (rst),
        .beat_valid   (beat_valid),
        .beat_ready   (beat_ready),
        .beat_sop     (beat_sop),
        .hdr_first_be (hdr_first_be),
        .hdr_last_be  (hdr_last_be),
        .hdr_dw_cnt   (hdr_dw_cnt),
        .hdr_zero_len (hdr_zero_len),
        .hdr_start_dw (hdr_start_dw),
        .cur_ctx      (cur_ctx),
        .cur_len      (cur_len),
        .cur_base     (cur_base)
    );

    wbe_lane_map #(
        .BEAT_DW (BEAT_DW),
        .LEN_W   (LEN_W),
        .OFS_W   (OFS_W)
    ) u_map (
        .beat_valid (beat_valid),
        .ctx        (cur_ctx),
        .len        (cur_len),
        .base       (cur_base),
        .lane_be    (lane_be)
    );

    wbe_sideband u_sb (
        .beat_valid   (beat_valid),
        .beat_sop     (beat_sop),
        .hdr_first_be (hdr_first_be),
        .hdr_last_be  (hdr_last_be),
        .sb_first_be  (sb_first_be),
        .sb_last_be   (sb_last_be)
    );

    // Lowest set bit, used to test that the set bits form one run.
    logic [BYTES-1:0] be_low;
    logic             be_contig;
    assign be_low    = lane_be & (~lane_be + BYTES'(1));
    assign be_contig = ((lane_be + be_low) & lane_be) == '0;

    AST_DESC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_sop) |-> lane_be[DESC_B-1:0] == '0) else $error("desc lanes"); // R1

    AST_START_RANGE: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_sop) |-> int'(hdr_start_dw) >= DESC_DW) else $error("start lane"); // R1

    AST_NULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_sop && hdr_zero_len) |-> lane_be == '0) else $error("zero length"); // R8

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |-> lane_be == '0) else $error("idle lanes"); // R11

    AST_SB_LATER: assert property (@(posedge clk) disable iff (rst)
        !(beat_valid && beat_sop) |-> (sb_first_be == '0 && sb_last_be == '0)) else $error("sideband"); // R9

    AST_RUN_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && int'(cur_len) > 2 && !cur_ctx.null_wr
         && head_legal(cur_ctx.head_be) && tail_legal(cur_ctx.tail_be)) |-> be_contig) else $error("run"); // R5

endmodule

// File: tb/wr_byte_en_gen_tb_top.sv
`timescale 1ns/1ps
module wr_byte_en_gen_tb_top;

    localparam int BEAT_DW = 16;
    localparam int BYTES   = 64;
    localparam int NVEC    = 8;

    // {first[4], last[4], count[11], zero[1], start[4]}
    localparam logic [23:0] VEC [NVEC] = '{
        {4'b0110, 4'b1111, 11'd1,  1'b0, 4'd4},
        {4'b0001, 4'b1000, 11'd2,  1'b0, 4'd5},
        {4'b1100, 4'b0011, 11'd40, 1'b0, 4'd7},
        {4'b1111, 4'b1111, 11'd7,  1'b1, 4'd6},
        {4'b1110, 4'b0111, 11'd2,  1'b0, 4'd15},
        {4'b1111, 4'b1111, 11'd5,  1'b0, 4'd8},
        {4'b1000, 4'b0001, 11'd29, 1'b0, 4'd4},
        {4'b1000, 4'b0001, 11'd3,  1'b0, 4'd14}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             beat_valid = 1'b0;
    logic             beat_ready = 1'b0;
    logic             beat_sop = 1'b0;
    logic [3:0]       hdr_first_be = '0;
    logic [3:0]       hdr_last_be = '0;
    logic [10:0]      hdr_dw_cnt = '0;
    logic             hdr_zero_len = 1'b0;
    logic [3:0]       hdr_start_dw = 4'd4;
    logic [BYTES-1:0] lane_be;
    logic [3:0]       sb_first_be;
    logic [3:0]       sb_last_be;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    wr_byte_en_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .beat_valid   (beat_valid),
        .beat_ready   (beat_ready),
        .beat_sop     (beat_sop),
        .hdr_first_be (hdr_first_be),
        .hdr_last_be  (hdr_last_be),
        .hdr_dw_cnt   (hdr_dw_cnt),
        .hdr_zero_len (hdr_zero_len),
        .hdr_start_dw (hdr_start_dw),
        .lane_be      (lane_be),
        .sb_first_be  (sb_first_be),
        .sb_last_be   (sb_last_be)
    );

    // Byte-level model of the requirements.
    function automatic logic [BYTES-1:0] model_be(input logic [3:0] f, input logic [3:0] l,
                                                  input int cnt, input logic z, input int st,
                                                  input int beat);
        logic [BYTES-1:0] v;
        int n;
        n = z ? 1 : cnt;
        v = '0;
        for (int k = 0; k < BYTES; k++) begin
            int p;
            p = beat * BEAT_DW + k / 4 - st;
            if (p >= 0 && p < n && !z) begin
                if (p == 0)          v[k] = f[k % 4];
                else if (p == n - 1) v[k] = l[k % 4];
                else                 v[k] = 1'b1;
            end
        end
        return v;
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R6";
            1: return "R7";
            2: return "R5";
            3: return "R8";
            4: return "R4";
            5: return "R2";
            6: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic check64(input string req, input logic [BYTES-1:0] act, input logic [BYTES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lane_be actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sideband actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic sop, input logic rdy);
        @(negedge clk);
        beat_valid = v;
        beat_sop   = sop;
        beat_ready = rdy;
        #1;
    endtask

    task automatic run_pkt(input logic [23:0] vec, input string req, input int stall_beat);
        logic [3:0] f;
        logic [3:0] l;
        int cnt;
        logic z;
        int st;
        int nb;
        f   = vec[23:20];
        l   = vec[19:16];
        cnt = int'(vec[15:5]);
        z   = vec[4];
        st  = int'(vec[3:0]);
        nb  = (st + (z ? 1 : cnt) + BEAT_DW - 1) / BEAT_DW;
        hdr_first_be = f;
        hdr_last_be  = l;
        hdr_dw_cnt   = vec[15:5];
        hdr_zero_len = z;
        hdr_start_dw = vec[3:0];
        for (int b = 0; b < nb; b++) begin
            if (b == stall_beat) begin
                drive(1'b1, b == 0, 1'b0);
                check64("R10 stall", lane_be, model_be(f, l, cnt, z, st, b));
            end
            drive(1'b1, b == 0, 1'b1);
            check64(req, lane_be, model_be(f, l, cnt, z, st, b));
            if (b == 0) begin
                check64("R1", {48'h0, lane_be[15:0]}, 64'h0);
                check8("R9 first", {sb_first_be, sb_last_be}, {f, l});
            end else begin
                check8("R9 later", {sb_first_be, sb_last_be}, 8'h00);
            end
        end
        drive(1'b0, 1'b0, 1'b1);
        check64("R11", lane_be, 64'h0);
        check8("R9 idle", {sb_first_be, sb_last_be}, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: a stray non-first beat right after reset carries no enables
        drive(1'b1, 1'b0, 1'b1);
        check64("R12", lane_be, 64'h0);
        check8("R12 sideband", {sb_first_be, sb_last_be}, 8'h00);
        drive(1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            run_pkt(VEC[i], vec_tag(i), -1);
        end

        // R10: stall in the middle of a multi-beat packet, then on the first beat
        run_pkt(VEC[2], "R10", 1);
        run_pkt(VEC[6], "R10", 0);

        // R11: idle with the header lines still loaded
        drive(1'b0, 1'b1, 1'b1);
        check64("R11 idle sop", lane_be, 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule